// File: doc/BRIEF.md
# Fuse Block Mapping Controller

This block manages a one-time-programmable fuse store made of 16-byte blocks and reached through five 32-bit registers. The host fills four data registers, writes a control word that holds a block address and an operation mode, and sets the start bit. The start bit reads back as 1 until the operation ends, and then it clears itself.

Physical read copies one block into the data registers. Physical write merges the data registers into one block with a bitwise OR, because a fuse bit cannot return to 0. Logical read treats the last three blocks as a table of one-byte map entries. It scans that table one entry per clock, looking for the first valid entry that names the requested address. The index of that entry is the physical block to load. If the scan finds nothing, the controller returns a dedicated not-found code and a block of all ones.

In this model the fuse store is an internal flop array. Reset blanks it to all zeros.

Top module: `efuse_map_ctrl`

## Requirements
- R1: After reset, the control register and all four data registers read 0, and every fuse block reads back as zeros.
- R2: Register 0 is the control word: bit 30 = start/busy, bits 25:16 = address, bits 7:6 = mode, bits 5:0 = result block (read-only). A physical read or write holds bit 30 at 1 for exactly one cycle after the start write.
- R3: A physical read (mode 1) of block B puts bytes 3..0 in register 4, bytes 7..4 in register 3, bytes B..8 in register 2 and bytes F..C in register 1. The lowest-numbered byte of each group sits in bits 7:0.
- R4: A physical write (mode 3) ORs the data registers into block B, using the same byte placement. A bit already at 1 is never cleared.
- R5: An address whose block number (address bits 9:4) is 48 or more reads back as all ones. A write to such an address changes no block.
- R6: Address bits 3:0 are ignored. They read back as 0 and have no effect on any operation.
- R7: A map entry is valid only if all of the following hold: it is nonzero, its bits 6:0 are not all ones (the invalidated form), bit 6 equals the inverse of the XOR of bits 3:0, and bit 7 equals the inverse of the XOR of bits 5:2. Bits 5:0 carry address bits 9:4.
- R8: A logical read (mode 0) scans map entries in ascending order, where the entry at map byte k (byte 720+k of the store) names physical block k. The first valid entry whose bits 5:0 equal the requested address bits 9:4 wins. Its index goes to the result field, and block k goes to the data registers.
- R9: A zero map byte ends the scan as a miss. A miss sets the result field to 0x3F and all four data registers to 0xFFFFFFFF.
- R10: The scan examines one entry per cycle, and only entries 0 to 44; the last 3 bytes of the store are never examined. A scan that ends at entry k keeps the busy bit at 1 for k+1 cycles, and a scan with no zero byte and no match takes 45 cycles.
- R11: Mode 2 finishes in one cycle and changes no data register, no result field and no fuse bit.
- R12: While busy, host writes to any register are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 control, 1 to 4 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |

## Verification
The hardest conditions to reach are the ones that depend on the contents of the map. The bench has to produce a rejected parity entry placed ahead of a good one, a duplicate mapping that only becomes visible after the earlier entry is invalidated, and a map with no zero byte at all. The store can only be filled through OR-merging physical writes, so the bench programs the map region with those writes in stages. It first lays down valid, bad-parity and duplicate entries. It then invalidates one of them by ORing 0x7F into it. Finally it saturates every scanned byte, and places a valid-looking entry in the reserved tail. The bench also counts the cycles the busy bit stays high for each case.

// File: rtl/efuse_map_ctrl.sv
module efuse_map_ctrl #(
  parameter int NBLK     = 48,
  parameter int MAP_BLKS = 3,
  parameter int MAP_RSV  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int BPB      = 16;
  localparam int NBYTE    = NBLK * BPB;
  localparam int MAP_BASE = (NBLK - MAP_BLKS) * BPB;
  localparam int NENT     = MAP_BLKS * BPB - MAP_RSV;
  localparam logic [5:0] LAST_IDX = 6'(NENT - 1);
  localparam logic [5:0] NBLK_V   = 6'(NBLK);
  localparam logic [5:0] MISS     = 6'h3F;
  localparam logic [1:0] M_LRD = 2'd0, M_PRD = 2'd1, M_PWR = 2'd3;

  logic [7:0]   fz [NBYTE];
  logic [127:0] blk_flat [NBLK];
  logic [7:0]   map_ent [NENT];
  logic [31:0]  dreg [4];
  logic [5:0]   blk_q, res_q, idx_q;
  logic [1:0]   mode_q;
  logic         busy_q;

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    always_comb
      for (int y = 0; y < BPB; y++) blk_flat[b][8*y +: 8] = fz[b*BPB + y];
  end

  for (genvar k = 0; k < NENT; k++) begin : g_map
    assign map_ent[k] = fz[MAP_BASE + k];
  end

  logic [5:0]   sel;
  logic [127:0] rblk, wblk;
  assign sel  = (mode_q == M_LRD) ? idx_q : blk_q;
  assign rblk = (sel < NBLK_V) ? blk_flat[sel] : '1;
  assign wblk = {dreg[0], dreg[1], dreg[2], dreg[3]};

  logic [7:0] ent;
  logic       par_ok, ent_live, hit, stop;
  assign ent      = map_ent[idx_q];
  assign par_ok   = (ent[6] == ~^ent[3:0]) && (ent[7] == ~^ent[5:2]);
  assign ent_live = (ent != 8'h00) && (ent[6:0] != 7'h7F) && par_ok;
  assign hit      = ent_live && (ent[5:0] == blk_q);
  assign stop     = (ent == 8'h00) || (idx_q == LAST_IDX);

  logic pw_fire;
  assign pw_fire = busy_q && (mode_q == M_PWR) && (blk_q < NBLK_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTE; i++) fz[i] <= 8'h00;
    end else if (pw_fire) begin
      for (int i = 0; i < NBYTE; i++)
        if (int'(blk_q) == i / BPB) fz[i] <= fz[i] | wblk[8*(i % BPB) +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= '0;
      res_q  <= '0;
      idx_q  <= '0;
      mode_q <= M_LRD;
      busy_q <= 1'b0;
      for (int j = 0; j < 4; j++) dreg[j] <= '0;
    end else if (!busy_q) begin
      if (reg_wr) begin
        if (reg_addr == 3'd0) begin
          blk_q  <= reg_wdata[25:20];
          mode_q <= reg_wdata[7:6];
          if (reg_wdata[30]) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
          end
        end else if (reg_addr <= 3'd4) begin
          dreg[2'(reg_addr - 3'd1)] <= reg_wdata;
        end
      end
    end else begin
      case (mode_q)
        M_LRD: begin
          if (hit) begin
            res_q  <= idx_q;
            busy_q <= 1'b0;
            for (int j = 0; j < 4; j++) dreg[j] <= rblk[32*(3-j) +: 32];
          end else if (stop) begin
            res_q  <= MISS;
            busy_q <= 1'b0;
            for (int j = 0; j < 4; j++) dreg[j] <= '1;
          end else begin
            idx_q <= idx_q + 6'd1;
          end
        end
        M_PRD: begin
          busy_q <= 1'b0;
          for (int j = 0; j < 4; j++) dreg[j] <= rblk[32*(3-j) +: 32];
        end
        default: busy_q <= 1'b0;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {1'b0, busy_q, 4'b0, blk_q, 4'b0, 8'b0, mode_q, res_q};
      3'd1:    reg_rdata = dreg[0];
      3'd2:    reg_rdata = dreg[1];
      3'd3:    reg_rdata = dreg[2];
      3'd4:    reg_rdata = dreg[3];
      default: reg_rdata = '0;
    endcase
  end

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[31], reg_wdata[29:26], reg_wdata[19:8], reg_wdata[5:0]};

  for (genvar i = 0; i < NBYTE; i++) begin : g_chk
    AST_FUSE_ONLY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (fz[i] & $past(fz[i])) == $past(fz[i])); // R4
  end

  AST_PHYS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && mode_q != M_LRD) |=> !busy_q); // R2
  AST_SCAN_IN_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> idx_q <= LAST_IDX); // R10
  AST_MISS_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && mode_q == M_LRD && res_q == MISS)
      |-> ((dreg[0] & dreg[1] & dreg[2] & dreg[3]) == '1)); // R9
  AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && mode_q == M_LRD && res_q != MISS) |-> res_q <= LAST_IDX); // R8
  AST_BUSY_LOCKS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(blk_q) && $stable(mode_q))); // R12
  AST_IDLE_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |=> $stable(res_q)); // R11
endmodule

// File: tb/sim_efuse_map_ctrl.sv
module sim_efuse_map_ctrl;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  always #(CLK_NS/2) clk = ~clk;

  efuse_map_ctrl u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
                     .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  typedef struct { int req; logic [2:0] a; logic [31:0] e; } item_t;
  item_t sb[$];
  logic  pend = 1'b0;
  int    n_chk = 0, n_bad = 0;
  logic [7:0] fm [768];

  always @(negedge clk) begin
    if (pend && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if (reg_rdata !== it.e) begin
        n_bad++;
        $display("FAIL R%0d reg%0d: actual %h expected %h", it.req, it.a, reg_rdata, it.e);
      end
    end
  end

  task automatic chk(int req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL R%0d busy cycles: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd_exp(logic [2:0] a, logic [31:0] e, int req);
    item_t it;
    it.req = req; it.a = a; it.e = e;
    reg_addr = a;
    sb.push_back(it);
    pend = 1'b1;
    @(posedge clk); #1;
    pend = 1'b0;
  endtask

  function automatic logic [31:0] ctrl_word(logic [9:0] a, logic [1:0] m, logic [5:0] r);
    return {2'b00, 4'b0, a[9:4], 4'b0, 8'b0, m, r};
  endfunction

  function automatic logic [127:0] mblk(int blk);
    logic [127:0] v;
    if (blk >= 48) return '1;
    for (int y = 0; y < 16; y++) v[8*y +: 8] = fm[blk*16 + y];
    return v;
  endfunction

  function automatic logic [7:0] mk_entry(logic [5:0] t);
    logic p6, p7;
    p6 = ~(t[0] ^ t[1] ^ t[2] ^ t[3]);
    p7 = ~(t[2] ^ t[3] ^ t[4] ^ t[5]);
    return {p7, p6, t};
  endfunction

  function automatic logic entry_ok(logic [7:0] e);
    if (e == 8'h00 || e[6:0] == 7'h7F) return 1'b0;
    return e == mk_entry(e[5:0]);
  endfunction

  function automatic logic [127:0] pat(int seed);
    logic [127:0] v;
    for (int y = 0; y < 16; y++) v[8*y +: 8] = 8'(seed + 37*y);
    return v;
  endfunction

  task automatic kick(logic [9:0] a, logic [1:0] m);
    wr(3'd0, {1'b0, 1'b1, 4'b0, a, 8'b0, m, 6'b0});
  endtask

  task automatic poll(output int n);
    n = 0;
    forever begin
      reg_addr = 3'd0;
      @(negedge clk);
      if (!reg_rdata[30] || n > 100) break;
      n++;
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
  endtask

  task automatic check_data(logic [127:0] v, int req);
    for (int j = 0; j < 4; j++) rd_exp(3'(j + 1), v[32*(3-j) +: 32], req);
  endtask

  task automatic pwrite(int blk, logic [127:0] v, int req);
    int n;
    for (int j = 0; j < 4; j++) wr(3'(j + 1), v[32*(3-j) +: 32]);
    kick({6'(blk), 4'h0}, 2'd3);
    poll(n);
    chk(req, n, 1);
    if (blk < 48)
      for (int y = 0; y < 16; y++) fm[blk*16 + y] = fm[blk*16 + y] | v[8*y +: 8];
  endtask

  task automatic pread(int blk, int req);
    int n;
    kick({6'(blk), 4'h0}, 2'd1);
    poll(n);
    chk(req, n, 1);
    check_data(mblk(blk), req);
  endtask

  task automatic model_lookup(logic [5:0] t, output logic [5:0] res, output int steps);
    res = 6'h3F; steps = 45;
    for (int k = 0; k < 45; k++) begin
      if (fm[720 + k] == 8'h00) begin res = 6'h3F; steps = k + 1; return; end
      if (entry_ok(fm[720 + k]) && fm[720 + k][5:0] == t) begin
        res = 6'(k); steps = k + 1; return;
      end
    end
  endtask

  task automatic lookup(logic [9:0] a, int req);
    logic [5:0] r;
    int st, n;
    model_lookup(a[9:4], r, st);
    kick(a, 2'd0);
    poll(n);
    chk(req, n, st);
    rd_exp(3'd0, ctrl_word(a, 2'd0, r), req);
    check_data((r == 6'h3F) ? '1 : mblk(int'(r)), req);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] mp;
    int n;
    for (int i = 0; i < 768; i++) fm[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: reset state of all registers
    for (int a = 0; a < 5; a++) rd_exp(3'(a), 32'h0, 1);

    // R6, R2: address low nibble dropped, result field read-only
    wr(3'd0, {2'b00, 4'b0, 10'h12F, 8'b0, 2'd1, 6'h2A});
    rd_exp(3'd0, ctrl_word(10'h120, 2'd1, 6'h00), 6);

    // R3: byte placement on physical read; R1 blank fuse
    pwrite(5, pat(3), 3);
    for (int j = 1; j < 5; j++) wr(3'(j), 32'h0);
    pread(5, 3);
    pread(0, 1);

    // R4: OR merge never clears bits
    pwrite(5, ~pat(3) & pat(90), 4);
    pread(5, 4);

    // R7, R8: map with bad parity ahead of good entry and a duplicate
    pwrite(2, pat(50), 8);
    pwrite(6, pat(120), 8);
    pwrite(0, pat(7), 8);
    mp = '0;
    mp[8*0 +: 8] = mk_entry(6'h07);
    mp[8*1 +: 8] = mk_entry(6'h08);
    mp[8*2 +: 8] = mk_entry(6'h12) ^ 8'h40;
    mp[8*3 +: 8] = mk_entry(6'h09);
    mp[8*4 +: 8] = mk_entry(6'h0A);
    mp[8*5 +: 8] = mk_entry(6'h12);
    mp[8*6 +: 8] = mk_entry(6'h12);
    pwrite(45, mp, 7);
    lookup(10'h12F, 8);
    lookup(10'h070, 8);
    lookup(10'h0A0, 10);

    // R9: zero byte ends scan as miss
    lookup(10'h200, 9);

    // R12: writes during scan are ignored
    kick(10'h120, 2'd0);
    wr(3'd0, {1'b0, 1'b1, 4'b0, 10'h3F0, 8'b0, 2'd1, 6'b0});
    wr(3'd1, 32'hDEADBEEF);
    poll(n);
    rd_exp(3'd0, ctrl_word(10'h120, 2'd0, 6'd5), 12);
    check_data(mblk(5), 12);

    // R7: invalidated entry no longer matches; next duplicate wins
    mp = '0;
    mp[8*5 +: 8] = 8'h7F;
    pwrite(45, mp, 7);
    lookup(10'h120, 7);

    // R11: reserved mode changes nothing
    for (int j = 1; j < 5; j++) wr(3'(j), 32'hA5A50000 + 32'(j));
    kick(10'h010, 2'd2);
    poll(n);
    chk(11, n, 1);
    rd_exp(3'd0, ctrl_word(10'h010, 2'd2, 6'd6), 11);
    for (int j = 1; j < 5; j++) rd_exp(3'(j), 32'hA5A50000 + 32'(j), 11);
    pread(1, 11);

    // R5: block beyond the array
    pwrite(50, pat(200), 5);
    pread(50, 5);
    pread(18, 5);
    pread(2, 5);

    // R10: fully saturated map, valid-looking entry only in reserved tail
    pwrite(45, {16{8'h7F}}, 10);
    pwrite(46, {16{8'h7F}}, 10);
    mp = {16{8'h7F}};
    for (int y = 13; y < 16; y++) mp[8*y +: 8] = mk_entry(6'h01);
    pwrite(47, mp, 10);
    lookup(10'h010, 10);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule